// File: doc/BRIEF.md
# CPU Clock Source and Divider Control Register

This block holds one 8-bit control register on a simple address/data bus, together with the logic that picks the CPU clock from it. It does not create a derived clock. Two tick enables come in: one from the main clock and one from the subsystem clock. The block turns them into a single-cycle CPU clock-enable pulse train. On the main source the pulse rate is the main tick rate divided by 1, 2, 4, 8 or 16. On the subsystem source the rate is always half the subsystem tick rate.

The register also drives two static controls: an oscillator-stop output and a feedback-resistor disable output. A read-only status bit shows which source is really driving the CPU enable. When software asks for a different source, that bit changes only when the switch completes, on a tick of the newly requested source. The block refuses bus writes that would set an illegal value. It keeps the affected field unchanged and raises a one-cycle error flag.

Top module: `cpu_clk_sel_reg`

## Requirements
- R1: After reset the register reads 0x00. It is accessed only at address 0xFFFB; a write to any other address changes nothing, and a read of any other address returns 0x00.
- R2: Bit 7 of the register drives `osc_stop` (1 = stop the main oscillator, 0 = allow it) and reads back as written.
- R3: Bit 6 drives `fb_res_off`. A write of 1 to bit 6 is refused (bit 6 unchanged, error flag) if the subsystem source is currently requested, is active, or is requested by the same write. A write of 1 to bit 4 is refused (bit 4 unchanged, error flag) if bit 6 would be 1 after that write.
- R4: Bit 5 is the read-only active-source status (0 = main, 1 = subsystem). Bus writes to bit 5 have no effect.
- R5: While the main source is active, divider code c in bits 2:0 (0 to 4) gives one `cpu_en` pulse per 2^c main ticks, whatever the spacing between the ticks.
- R6: While the subsystem source is active, `cpu_en` pulses on every second subsystem tick for any legal divider code, and main ticks produce no pulse.
- R7: A write with divider code 5, 6 or 7 leaves bits 2:0 unchanged. A write with bit 3 = 1 leaves bit 3 at 0. Any refused field raises `wr_err` for exactly the one cycle after the write.
- R8: A change of the requested source (bit 4) takes effect on the next tick of the new source. At that same clock edge the status bit changes and `cpu_en` starts coming from the new source. Until then the old source keeps driving `cpu_en`.
- R9: An accepted write that changes the divider code restarts the main divider, so the next pulse comes after a full 2^c ticks.
- R10: `cpu_en` is high for one cycle only, in the cycle after a tick of the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0 when not addressed) |
| main_tick | input | 1 | Main clock tick enable |
| sub_tick | input | 1 | Subsystem clock tick enable |
| cpu_en | output | 1 | CPU clock-enable pulse |
| osc_stop | output | 1 | Main oscillator stop control |
| fb_res_off | output | 1 | Subsystem feedback resistor disable |
| wr_err | output | 1 | One-cycle flag for a refused write field |

## Verification
Every legal divider code is swept on the main source with two tick patterns: back-to-back ticks and ticks two idle cycles apart. Counting pulses in each pattern separates true division by ticks from division by system cycles. Each illegal code and the reserved bit are written to show that the field is held. A restart case is chosen so that an unreset counter would pulse early. Source switches are driven with ticks of only the old source first, then one tick of the new source. This shows whether the status bit and the pulse train move together and only on the correct tick.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int BIT_OSC  = 7;
  localparam int BIT_FB   = 6;
  localparam int BIT_STAT = 5;
  localparam int BIT_SRC  = 4;
  localparam int BIT_RSV  = 3;
  localparam int CODE_W   = 3;
  localparam int REG_W    = 8;
endpackage

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
#(
  parameter int MAX_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              stat_i,
  output logic              osc_q,
  output logic              fb_q,
  output logic              src_q,
  output logic [CODE_W-1:0] code_q,
  output logic              code_chg,
  output logic              err_q
);
  logic              osc_d, fb_d, src_d, err_d;
  logic [CODE_W-1:0] code_d;
  logic              code_bad, rsv_bad, fb_bad, src_bad;
  logic              unused_stat_bit;

  assign unused_stat_bit = wdata[BIT_STAT];

  always_comb begin
    code_bad = (wdata[CODE_W-1:0] > CODE_W'(MAX_CODE));
    rsv_bad  = wdata[BIT_RSV];
    fb_bad   = wdata[BIT_FB] & (src_q | stat_i | wdata[BIT_SRC]);
    osc_d    = osc_q;
    fb_d     = fb_q;
    src_d    = src_q;
    code_d   = code_q;
    src_bad  = 1'b0;
    if (wr_en) begin
      osc_d   = wdata[BIT_OSC];
      fb_d    = fb_bad ? fb_q : wdata[BIT_FB];
      src_bad = wdata[BIT_SRC] & fb_d;
      src_d   = src_bad ? src_q : wdata[BIT_SRC];
      code_d  = code_bad ? code_q : wdata[CODE_W-1:0];
    end
    err_d    = wr_en & (code_bad | rsv_bad | fb_bad | src_bad);
    code_chg = wr_en & ~code_bad & (wdata[CODE_W-1:0] != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q  <= 1'b0;
      fb_q   <= 1'b0;
      src_q  <= 1'b0;
      code_q <= '0;
      err_q  <= 1'b0;
    end else begin
      osc_q  <= osc_d;
      fb_q   <= fb_d;
      src_q  <= src_d;
      code_q <= code_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/ccr_main_div.sv
module ccr_main_div
  import ccr_pkg::*;
#(
  parameter int MAX_CODE = 4,
  localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  input  logic              align,
  output logic              pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff, last;

  for (genvar i = 0; i < CNT_W; i++) begin : g_last
    assign last[i] = (code > CODE_W'(i));
  end

  always_comb begin
    cnt_eff = align ? '0 : cnt_q;
    pulse   = tick & ~restart & (cnt_eff == last);
    cnt_d   = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (tick)
      cnt_d = (cnt_eff == last) ? '0 : cnt_eff + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ccr_sub_div.sv
module ccr_sub_div (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic align,
  output logic pulse
);
  logic tog_q, tog_d, tog_eff;

  always_comb begin
    tog_eff = align ? 1'b0 : tog_q;
    pulse   = tick & tog_eff;
    tog_d   = tick ? ~tog_eff : tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end
endmodule

// File: rtl/cpu_clk_sel_reg.sv
module cpu_clk_sel_reg
  import ccr_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFFB,
  parameter int              MAX_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              main_tick,
  input  logic              sub_tick,
  output logic              cpu_en,
  output logic              osc_stop,
  output logic              fb_res_off,
  output logic              wr_err
);
  logic              hit, wr_en;
  logic              osc_q, fb_off, src_req, code_chg;
  logic [CODE_W-1:0] div_code;
  logic              stat_q, stat_d, en_q, en_d;
  logic              sw_main, sw_sub, main_pulse, sub_pulse;

  assign hit   = bus_sel & (bus_addr == REG_ADDR);
  assign wr_en = hit & bus_wr;

  ccr_regfile #(.MAX_CODE(MAX_CODE)) reg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
    .stat_i(stat_q), .osc_q(osc_q), .fb_q(fb_off), .src_q(src_req),
    .code_q(div_code), .code_chg(code_chg), .err_q(wr_err)
  );

  assign sw_main = stat_q & ~src_req & main_tick;
  assign sw_sub  = ~stat_q & src_req & sub_tick;

  ccr_main_div #(.MAX_CODE(MAX_CODE)) mdiv_i (
    .clk(clk), .rst_n(rst_n), .tick(main_tick), .code(div_code),
    .restart(code_chg), .align(sw_main), .pulse(main_pulse)
  );

  ccr_sub_div sdiv_i (
    .clk(clk), .rst_n(rst_n), .tick(sub_tick), .align(sw_sub),
    .pulse(sub_pulse)
  );

  always_comb begin
    stat_d = (sw_main | sw_sub) ? src_req : stat_q;
    en_d   = stat_d ? sub_pulse : main_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_wr) begin
      bus_rdata[BIT_OSC]  = osc_q;
      bus_rdata[BIT_FB]   = fb_off;
      bus_rdata[BIT_STAT] = stat_q;
      bus_rdata[BIT_SRC]  = src_req;
      bus_rdata[CODE_W-1:0] = div_code;
    end
  end

  assign cpu_en     = en_q;
  assign osc_stop   = osc_q;
  assign fb_res_off = fb_off;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFFB,
  parameter int              MAX_CODE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              main_tick,
  input logic              sub_tick,
  input logic              cpu_en,
  input logic              wr_err,
  input logic              stat_q,
  input logic              src_req,
  input logic              fb_off,
  input logic [CODE_W-1:0] div_code
);
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    div_code <= CODE_W'(MAX_CODE)); // R7
  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(bus_sel && bus_wr && bus_addr == REG_ADDR)); // R7
  AST_EN_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> (stat_q ? $past(sub_tick) : $past(main_tick))); // R10
  AST_TO_SUB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> ($past(sub_tick) && $past(src_req))); // R8
  AST_TO_MAIN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> ($past(main_tick) && !$past(src_req))); // R8
  AST_FB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_off |-> (!src_req && !stat_q)); // R3
  AST_SUB_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && cpu_en) |=> !(stat_q && cpu_en)); // R6
endmodule

bind cpu_clk_sel_reg ccr_checker #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .MAX_CODE(MAX_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .main_tick(main_tick), .sub_tick(sub_tick),
  .cpu_en(cpu_en), .wr_err(wr_err), .stat_q(stat_q), .src_req(src_req),
  .fb_off(fb_off), .div_code(div_code)
);

// File: tb/cpu_clk_sel_reg_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_sel_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic        main_tick = 1'b0, sub_tick = 1'b0;
  logic        cpu_en, osc_stop, fb_res_off, wr_err;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cpu_clk_sel_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .main_tick(main_tick), .sub_tick(sub_tick), .cpu_en(cpu_en),
    .osc_stop(osc_stop), .fb_res_off(fb_res_off), .wr_err(wr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, output logic err);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    err = wr_err;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input bit use_sub, input int n, input int gap, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      if (use_sub) sub_tick = 1'b1; else main_tick = 1'b1;
      @(negedge clk);
      p += int'(cpu_en);
      main_tick = 1'b0; sub_tick = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        p += int'(cpu_en);
      end
    end
  endtask

  localparam logic [15:0] A = 16'hFFFB;

  initial begin
    logic [7:0] d;
    logic e;
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A, d);       chk("R1 reset value", d, 8'h00);
    chk("R1 reset outputs", {osc_stop, fb_res_off, cpu_en, wr_err}, 0);
    wr(16'hFFFA, 8'h80, e);
    chk("R1 other address write", osc_stop, 0);
    rd(16'hFFFA, d); chk("R1 other address read", d, 8'h00);
    wr(A, 8'h80, e); rd(A, d);
    chk("R2 osc stop set", {osc_stop, d}, {1'b1, 8'h80});
    wr(A, 8'h00, e);
    chk("R2 osc stop clear", osc_stop, 0);
    for (int c = 0; c <= 4; c++) begin
      wr(A, 8'(c), e); rd(A, d);
      chk("R5 code readback", d, c);
      ticks(1'b0, 64, 0, p);
      chk($sformatf("R5 code %0d dense ticks", c), p, 64 >> c);
      ticks(1'b0, 32, 2, p);
      chk($sformatf("R5 code %0d sparse ticks", c), p, 32 >> c);
    end
    for (int c = 5; c <= 7; c++) begin
      wr(A, 8'(c), e); rd(A, d);
      chk($sformatf("R7 code %0d error", c), e, 1);
      chk($sformatf("R7 code %0d held", c), d, 8'h04);
    end
    wr(A, 8'h0A, e); rd(A, d);
    chk("R7 bit3 error", e, 1);
    chk("R7 bit3 held zero", d, 8'h02);
    @(negedge clk);
    chk("R7 error lasts one cycle", wr_err, 0);
    wr(A, 8'h24, e); rd(A, d);
    chk("R4 status write ignored", {e, d}, {1'b0, 8'h04});
    wr(A, 8'h02, e);
    ticks(1'b0, 3, 0, p); chk("R9 before restart", p, 0);
    wr(A, 8'h03, e);
    ticks(1'b0, 7, 0, p); chk("R9 no early pulse", p, 0);
    ticks(1'b0, 1, 0, p); chk("R9 pulse after full count", p, 1);
    wr(A, 8'h13, e); rd(A, d);
    chk("R8 request pending", d, 8'h13);
    ticks(1'b0, 8, 0, p); chk("R8 old source runs", p, 1);
    rd(A, d); chk("R8 no switch on main tick", d, 8'h13);
    ticks(1'b1, 1, 0, p); rd(A, d);
    chk("R8 switch on sub tick", d, 8'h33);
    chk("R8 first sub tick no pulse", p, 0);
    ticks(1'b1, 19, 0, p); chk("R6 sub half rate", p, 10);
    ticks(1'b0, 16, 0, p); chk("R6 main ticks ignored", p, 0);
    wr(A, 8'h10, e);
    ticks(1'b1, 8, 1, p); chk("R6 code does not matter", p, 4);
    wr(A, 8'h50, e); rd(A, d);
    chk("R3 fb refused on sub", {e, fb_res_off, d}, {1'b1, 1'b0, 8'h30});
    wr(A, 8'h00, e); rd(A, d);
    chk("R8 back request pending", d, 8'h20);
    ticks(1'b1, 4, 0, p); chk("R8 sub keeps running", p, 2);
    ticks(1'b0, 1, 0, p); rd(A, d);
    chk("R8 switch to main with pulse", {p[0], d}, {1'b1, 8'h00});
    wr(A, 8'h40, e); rd(A, d);
    chk("R3 fb set on main", {e, fb_res_off, d}, {1'b0, 1'b1, 8'h40});
    wr(A, 8'h50, e); rd(A, d);
    chk("R3 sub refused while fb off", {e, d}, {1'b1, 8'h40});
    wr(A, 8'h10, e); rd(A, d);
    chk("R3 fb clear with sub request", {e, fb_res_off, d}, {1'b0, 1'b0, 8'h10});
    chk("R10 pulse is single", cpu_en, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule